// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block keeps the saved-context state of a small RISC core: the status register, the saved status, the saved program counter and the event-code register. When the pipeline reports an exception, the block picks the program counter to save. The choice depends on whether the exception re-executes the faulting instruction or completes it, and on whether the faulting instruction is a delayed branch or sits in a branch's delay slot. The block also copies the status word aside, sets the block bit and records the event code, all on one clock edge.

An exception that arrives while the block bit is already set, other than a user break, becomes a manual reset. The event code is forced to 0x20 and the status register goes back to its reset value. A return command restores the status word from the saved copy and hands the saved program counter to fetch. For the one instruction that follows the return, the block also presents the status word as it was before the restore, which fetch uses to judge instruction-access faults.

Top module: `exc_ctx_ctrl`

## Requirements
- R1: After reset, `sr_o` is 0x700000F0 with the block bit (bit 28) set, `ssr_o`, `spc_o` and `evt_o` are 0, and `mrst_o` and `ret_vld_o` are 0.
- R2: A taken exception with `exc_kind`=0 (re-execute) and `in_slot`=0 saves `cur_pc` into `spc_o`.
- R3: A taken exception with `exc_kind`=0 and `in_slot`=1 saves `br_pc`, the address of the delayed branch, whatever the value of `is_dbr`.
- R4: A taken exception with `exc_kind` of 1 (completion), 2 (interrupt) or 3 (handled as completion) and `is_dbr`=0 saves `nxt_pc`, whatever the value of `in_slot`.
- R5: A taken exception with `exc_kind` of 1, 2 or 3 and `is_dbr`=1 saves `tgt_pc`, the branch target.
- R6: On the clock edge after an ordinary entry, `ssr_o` holds the previous `sr_o`, `sr_o` equals the previous value with bit 28 set, and `evt_o` equals `exc_code`.
- R7: An exception with `exc_ubrk`=0 while bit 28 of `sr_o` is 1 sets `evt_o` to 0x20, sets `sr_o` to 0x700000F0, leaves `spc_o` and `ssr_o` unchanged, and raises `mrst_o` for one cycle.
- R8: A user-break exception (`exc_ubrk`=1) while bit 28 is 1 is an ordinary entry as in R6, and `mrst_o` stays 0.
- R9: After a return command, on the next cycle `sr_o` equals the previous `ssr_o`, `ret_vld_o` is 1 for that one cycle, and `ret_pc_o` equals `spc_o`.
- R10: During the cycle in which `ret_vld_o` is 1, `slot_sr_o` shows the status word from before the restore. In every other cycle it equals `sr_o`.
- R11: When `exc_req` and `rte_req` are both high in the same cycle, the exception is taken and the return is dropped, so `ret_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | Exception or interrupt request, one cycle |
| exc_kind | input | 2 | 0 re-execute, 1 completion, 2 interrupt, 3 handled as completion |
| exc_ubrk | input | 1 | Request is a user break |
| exc_code | input | CODE_W | Event code to record on ordinary entry |
| cur_pc | input | PC_W | Address of the faulting instruction |
| nxt_pc | input | PC_W | Address of the following instruction |
| tgt_pc | input | PC_W | Target of the faulting delayed branch |
| br_pc | input | PC_W | Address of the delayed branch owning the slot |
| in_slot | input | 1 | Faulting instruction sits in a delay slot |
| is_dbr | input | 1 | Faulting instruction is a delayed branch |
| rte_req | input | 1 | Return-from-exception command, one cycle |
| sr_o | output | SR_W | Status register |
| ssr_o | output | SR_W | Saved status register |
| spc_o | output | PC_W | Saved program counter |
| evt_o | output | CODE_W | Event-code register |
| mrst_o | output | 1 | Manual-reset pulse |
| ret_vld_o | output | 1 | Return redirect valid |
| ret_pc_o | output | PC_W | Return redirect address |
| slot_sr_o | output | SR_W | Status word used for the return slot's fetch checks |

## Verification
A wrong internal selection shows at `spc_o` on the very next edge, and it shows again at `ret_pc_o` one cycle after the matching return. For that reason the bench pairs every entry with a return and checks both. A block bit that is stuck or wrongly set shows up at the next exception: either `mrst_o` rises with `evt_o` at 0x20 when it should not, or it fails to rise when it should. A lost pre-restore copy of the status word is visible only during the single cycle of `ret_vld_o`, so `slot_sr_o` is sampled exactly in that cycle and once more after it.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;
   typedef enum logic [1:0] {
      EK_REEXEC = 2'd0,
      EK_COMPL  = 2'd1,
      EK_INTR   = 2'd2,
      EK_RSVD   = 2'd3
   } exc_kind_e;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_ENTRY = 2'd1,
      ACT_MRST  = 2'd2,
      ACT_RET   = 2'd3
   } ctx_act_e;
endpackage

// File: rtl/exc_spc_sel.sv
module exc_spc_sel
   import exc_ctx_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [1:0]      kind,
   input  logic            in_slot,
   input  logic            is_dbr,
   input  logic [PC_W-1:0] cur_pc,
   input  logic [PC_W-1:0] nxt_pc,
   input  logic [PC_W-1:0] tgt_pc,
   input  logic [PC_W-1:0] br_pc,
   output logic [PC_W-1:0] spc_new
);
   exc_kind_e kind_e;
   assign kind_e = exc_kind_e'(kind);

   always_comb begin
      case (kind_e)
         EK_REEXEC: spc_new = in_slot ? br_pc : cur_pc;
         default:   spc_new = is_dbr  ? tgt_pc : nxt_pc;
      endcase
   end
endmodule

// File: rtl/exc_ctx_decide.sv
module exc_ctx_decide
   import exc_ctx_pkg::*;
(
   input  logic     exc_req,
   input  logic     exc_ubrk,
   input  logic     blocked,
   input  logic     rte_req,
   output ctx_act_e act
);
   always_comb begin
      act = ACT_NONE;
      if (exc_req) begin
         if (blocked && !exc_ubrk) act = ACT_MRST;
         else                      act = ACT_ENTRY;
      end else if (rte_req) begin
         act = ACT_RET;
      end
   end
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
   import exc_ctx_pkg::*;
#(
   parameter int               PC_W      = 32,
   parameter int               SR_W      = 32,
   parameter int               CODE_W    = 32,
   parameter int               BL_BIT    = 28,
   parameter logic [SR_W-1:0]  SR_RST    = 32'h7000_00F0,
   parameter logic [CODE_W-1:0] MRST_CODE = 32'h20,
   parameter bit               RET_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctx_act_e          act,
   input  logic [PC_W-1:0]   spc_new,
   input  logic [CODE_W-1:0] exc_code,
   output logic [SR_W-1:0]   sr_q,
   output logic [SR_W-1:0]   ssr_q,
   output logic [PC_W-1:0]   spc_q,
   output logic [CODE_W-1:0] evt_q,
   output logic              mrst_q,
   output logic              ret_vld_q,
   output logic [PC_W-1:0]   ret_pc,
   output logic [SR_W-1:0]   slot_sr
);
   localparam logic [SR_W-1:0] BL_MASK = SR_W'(1) << BL_BIT;

   logic [SR_W-1:0] pre_sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q      <= SR_RST;
         ssr_q     <= '0;
         spc_q     <= '0;
         evt_q     <= '0;
         mrst_q    <= 1'b0;
         ret_vld_q <= 1'b0;
         pre_sr_q  <= '0;
      end else begin
         mrst_q    <= (act == ACT_MRST);
         ret_vld_q <= (act == ACT_RET);
         case (act)
            ACT_ENTRY: begin
               spc_q <= spc_new;
               ssr_q <= sr_q;
               sr_q  <= sr_q | BL_MASK;
               evt_q <= exc_code;
            end
            ACT_MRST: begin
               sr_q  <= SR_RST;
               evt_q <= MRST_CODE;
            end
            ACT_RET: begin
               pre_sr_q <= sr_q;
               sr_q     <= ssr_q;
            end
            default: ;
         endcase
      end
   end

   assign slot_sr = ret_vld_q ? pre_sr_q : sr_q;

   generate
      if (RET_REG) begin : g_ret_reg
         logic [PC_W-1:0] ret_pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ret_pc_q <= '0;
            else if (act == ACT_RET) ret_pc_q <= spc_q;
         end
         assign ret_pc = ret_pc_q;
      end else begin : g_ret_comb
         assign ret_pc = spc_q;
      end
   endgenerate
endmodule

// File: rtl/exc_ctx_ctrl.sv
module exc_ctx_ctrl
   import exc_ctx_pkg::*;
#(
   parameter int                PC_W      = 32,
   parameter int                SR_W      = 32,
   parameter int                CODE_W    = 32,
   parameter int                BL_BIT    = 28,
   parameter logic [SR_W-1:0]   SR_RST    = 32'h7000_00F0,
   parameter logic [CODE_W-1:0] MRST_CODE = 32'h20,
   parameter bit                RET_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [1:0]        exc_kind,
   input  logic              exc_ubrk,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [PC_W-1:0]   nxt_pc,
   input  logic [PC_W-1:0]   tgt_pc,
   input  logic [PC_W-1:0]   br_pc,
   input  logic              in_slot,
   input  logic              is_dbr,
   input  logic              rte_req,
   output logic [SR_W-1:0]   sr_o,
   output logic [SR_W-1:0]   ssr_o,
   output logic [PC_W-1:0]   spc_o,
   output logic [CODE_W-1:0] evt_o,
   output logic              mrst_o,
   output logic              ret_vld_o,
   output logic [PC_W-1:0]   ret_pc_o,
   output logic [SR_W-1:0]   slot_sr_o
);
   generate
      if (BL_BIT < 0 || BL_BIT >= SR_W) begin : g_bad_bl
         $error("exc_ctx_ctrl: BL_BIT outside status word");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("exc_ctx_ctrl: PC_W too small");
      end
      if (CODE_W < 6) begin : g_bad_code
         $error("exc_ctx_ctrl: CODE_W cannot hold the manual-reset code");
      end
      if (SR_RST[BL_BIT] != 1'b1) begin : g_bad_rst
         $error("exc_ctx_ctrl: reset status must set the block bit");
      end
   endgenerate

   logic [PC_W-1:0] spc_new;
   ctx_act_e        act;

   exc_spc_sel #(.PC_W(PC_W)) u_sel (
      .kind    (exc_kind),
      .in_slot (in_slot),
      .is_dbr  (is_dbr),
      .cur_pc  (cur_pc),
      .nxt_pc  (nxt_pc),
      .tgt_pc  (tgt_pc),
      .br_pc   (br_pc),
      .spc_new (spc_new)
   );

   exc_ctx_decide u_dec (
      .exc_req  (exc_req),
      .exc_ubrk (exc_ubrk),
      .blocked  (sr_o[BL_BIT]),
      .rte_req  (rte_req),
      .act      (act)
   );

   exc_ctx_regs #(
      .PC_W(PC_W), .SR_W(SR_W), .CODE_W(CODE_W), .BL_BIT(BL_BIT),
      .SR_RST(SR_RST), .MRST_CODE(MRST_CODE), .RET_REG(RET_REG)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .spc_new   (spc_new),
      .exc_code  (exc_code),
      .sr_q      (sr_o),
      .ssr_q     (ssr_o),
      .spc_q     (spc_o),
      .evt_q     (evt_o),
      .mrst_q    (mrst_o),
      .ret_vld_q (ret_vld_o),
      .ret_pc    (ret_pc_o),
      .slot_sr   (slot_sr_o)
   );
endmodule

// File: rtl/exc_ctx_ctrl_chk.sv
module exc_ctx_ctrl_chk #(
   parameter int                PC_W      = 32,
   parameter int                SR_W      = 32,
   parameter int                CODE_W    = 32,
   parameter int                BL_BIT    = 28,
   parameter logic [SR_W-1:0]   SR_RST    = 32'h7000_00F0,
   parameter logic [CODE_W-1:0] MRST_CODE = 32'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [1:0]        exc_kind,
   input logic              exc_ubrk,
   input logic [PC_W-1:0]   br_pc,
   input logic              in_slot,
   input logic              rte_req,
   input logic [SR_W-1:0]   sr_o,
   input logic [SR_W-1:0]   ssr_o,
   input logic [PC_W-1:0]   spc_o,
   input logic [CODE_W-1:0] evt_o,
   input logic              mrst_o,
   input logic              ret_vld_o,
   input logic [PC_W-1:0]   ret_pc_o,
   input logic [SR_W-1:0]   slot_sr_o
);
   AST_REEXEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !(sr_o[BL_BIT] && !exc_ubrk) && exc_kind == 2'd0 && in_slot
      |=> spc_o == $past(br_pc)); // R3
   AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !(sr_o[BL_BIT] && !exc_ubrk)
      |=> sr_o[BL_BIT] && ssr_o == $past(sr_o)); // R6
   AST_MRST_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && sr_o[BL_BIT] && !exc_ubrk
      |=> mrst_o && evt_o == MRST_CODE && sr_o == SR_RST
          && $stable(spc_o) && $stable(ssr_o)); // R7
   AST_UBRK_NO_MRST: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && exc_ubrk |=> !mrst_o); // R8
   AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      rte_req && !exc_req
      |=> ret_vld_o && sr_o == $past(ssr_o) && ret_pc_o == $past(spc_o)); // R9
   AST_SLOT_SR: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_vld_o |-> slot_sr_o == sr_o); // R10
   AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> !ret_vld_o); // R11
endmodule

bind exc_ctx_ctrl exc_ctx_ctrl_chk #(
   .PC_W(PC_W), .SR_W(SR_W), .CODE_W(CODE_W), .BL_BIT(BL_BIT),
   .SR_RST(SR_RST), .MRST_CODE(MRST_CODE)
) u_chk (.*);

// File: tb/exc_ctx_ctrl_tb.sv
module exc_ctx_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [1:0]  exc_kind = 2'd0;
   logic        exc_ubrk = 1'b0;
   logic [31:0] exc_code = '0;
   logic [31:0] cur_pc = '0, nxt_pc = '0, tgt_pc = '0, br_pc = '0;
   logic        in_slot = 1'b0, is_dbr = 1'b0, rte_req = 1'b0;
   logic [31:0] sr_o, ssr_o, spc_o, evt_o, ret_pc_o, slot_sr_o;
   logic        mrst_o, ret_vld_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [31:0] SR_RST = 32'h7000_00F0;
   localparam logic [31:0] BLM    = 32'h1000_0000;

   // kind[5:4] slot[3] dbr[2] sel[1:0]: sel 0 cur, 1 nxt, 2 tgt, 3 br
   localparam logic [5:0] VEC [8] = '{
      {2'd0, 1'b0, 1'b0, 2'd0},
      {2'd0, 1'b1, 1'b0, 2'd3},
      {2'd0, 1'b1, 1'b1, 2'd3},
      {2'd1, 1'b0, 1'b0, 2'd1},
      {2'd1, 1'b0, 1'b1, 2'd2},
      {2'd2, 1'b0, 1'b0, 2'd1},
      {2'd2, 1'b0, 1'b1, 2'd2},
      {2'd3, 1'b1, 1'b0, 2'd1}
   };

   always #5 clk = ~clk;

   exc_ctx_ctrl u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_pcs(input int i);
      cur_pc = 32'h1000 + 32'(i) * 16;
      nxt_pc = cur_pc + 2;
      tgt_pc = 32'h8000 + 32'(i) * 4;
      br_pc  = cur_pc - 2;
   endtask

   task automatic pulse_exc(input logic [1:0] k, input logic ub, input logic [31:0] code,
                            input logic sl, input logic db, input logic with_rte);
      @(negedge clk);
      exc_kind = k; exc_ubrk = ub; exc_code = code; in_slot = sl; is_dbr = db;
      exc_req = 1'b1; rte_req = with_rte;
      @(negedge clk);
      exc_req = 1'b0; rte_req = 1'b0;
   endtask

   task automatic pulse_rte();
      @(negedge clk);
      rte_req = 1'b1;
      @(negedge clk);
      rte_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_spc, keep_spc, keep_ssr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sr", sr_o, SR_RST);
      chk("R1 ssr", ssr_o, 32'h0);
      chk("R1 spc", spc_o, 32'h0);
      chk("R1 evt", evt_o, 32'h0);
      chk("R1 mrst/ret", {30'b0, mrst_o, ret_vld_o}, 32'h0);

      // blocked from reset: manual reset
      set_pcs(20);
      pulse_exc(2'd1, 1'b0, 32'h1E0, 1'b0, 1'b0, 1'b0);
      chk("R7 evt", evt_o, 32'h20);
      chk("R7 sr", sr_o, SR_RST);
      chk("R7 spc held", spc_o, 32'h0);
      chk("R7 ssr held", ssr_o, 32'h0);
      chk("R7 pulse", {31'b0, mrst_o}, 32'h1);
      @(negedge clk);
      chk("R7 pulse ends", {31'b0, mrst_o}, 32'h0);

      // return clears block bit (ssr = 0)
      @(negedge clk); rte_req = 1'b1;
      @(negedge clk); rte_req = 1'b0;
      chk("R9 valid", {31'b0, ret_vld_o}, 32'h1);
      chk("R9 sr", sr_o, 32'h0);
      chk("R9 pc", ret_pc_o, 32'h0);
      chk("R10 slot sr pre", slot_sr_o, SR_RST);
      @(negedge clk);
      chk("R9 valid ends", {31'b0, ret_vld_o}, 32'h0);
      chk("R10 slot sr after", slot_sr_o, 32'h0);

      // table of saved-PC selections
      for (int i = 0; i < 8; i++) begin
         set_pcs(i);
         case (VEC[i][1:0])
            2'd0: exp_spc = cur_pc;
            2'd1: exp_spc = nxt_pc;
            2'd2: exp_spc = tgt_pc;
            default: exp_spc = br_pc;
         endcase
         pulse_exc(VEC[i][5:4], 1'b0, 32'h100 + 32'(i), VEC[i][3], VEC[i][2], 1'b0);
         chk("R2/R3/R4/R5 spc", spc_o, exp_spc);
         chk("R6 ssr", ssr_o, 32'h0);
         chk("R6 sr", sr_o, BLM);
         chk("R6 evt", evt_o, 32'h100 + 32'(i));
         pulse_rte();
         chk("R9 pc", ret_pc_o, exp_spc);
         chk("R9 sr", sr_o, 32'h0);
      end

      // simultaneous exception and return
      set_pcs(9);
      pulse_exc(2'd0, 1'b0, 32'h0A0, 1'b0, 1'b0, 1'b1);
      chk("R11 no return", {31'b0, ret_vld_o}, 32'h0);
      chk("R11 spc", spc_o, cur_pc);
      chk("R6 sr set", sr_o, BLM);
      chk("R6 ssr", ssr_o, 32'h0);

      // user break while blocked
      set_pcs(10);
      pulse_exc(2'd1, 1'b1, 32'h1E0, 1'b0, 1'b0, 1'b0);
      chk("R8 no mrst", {31'b0, mrst_o}, 32'h0);
      chk("R8 evt", evt_o, 32'h1E0);
      chk("R8 ssr", ssr_o, BLM);
      chk("R8 spc", spc_o, nxt_pc);

      // blocked ordinary exception: state held
      keep_spc = spc_o; keep_ssr = ssr_o;
      set_pcs(11);
      pulse_exc(2'd0, 1'b0, 32'h0C0, 1'b1, 1'b0, 1'b0);
      chk("R7 evt", evt_o, 32'h20);
      chk("R7 spc held", spc_o, keep_spc);
      chk("R7 ssr held", ssr_o, keep_ssr);
      chk("R7 sr", sr_o, SR_RST);

      // return after manual reset: slot sees reset status
      pulse_rte();
      chk("R9 sr", sr_o, BLM);
      chk("R10 slot sr pre", slot_sr_o, SR_RST);
      chk("R9 pc", ret_pc_o, keep_spc);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule